// File: doc/BRIEF.md
# Internal Data Memory Access Decoder

This block sits between an 8051-style execution core and its data storage, and sends each data access to the right place. It holds 1 KB of on-chip RAM: a 256-byte scratchpad and a 768-byte expanded RAM. It also drives a request port towards the special function register (SFR) bus and a request port towards the external data bus. The core gives an address, an addressing mode, read and write strobes, write data, and a control bit that decides where move-external (MOVX) accesses go.

Byte addresses 80h to FFh are shared by two storages, and the addressing mode picks between them. An indirect access reaches the upper half of the scratchpad. A direct access reaches the SFR space and never the scratchpad. Move-external accesses go to the expanded RAM while the control bit is clear and the address is below the expanded RAM size. Otherwise they go to the external bus.

Reads return one cycle after the strobe on a single registered read port. For SFR and external reads, the data on the bus during the request cycle is captured and presented in the next cycle.

Top module: `dmem_route_top`

## Requirements
- R1: A direct access (req_mode = 0) with req_addr[7:0] below 80h reads or writes scratchpad byte req_addr[7:0]. Bits 15:8 of the address are ignored.
- R2: An indirect access (req_mode = 1) reaches scratchpad byte req_addr[7:0] over the full range 00h to FFh. This is the only way to reach bytes 80h to FFh.
- R3: A direct access with req_addr[7:0] at or above 80h asserts sfr_req in the same cycle, with sfr_addr = req_addr[7:0], sfr_we = req_wr and sfr_wdata = req_wdata. It leaves the scratchpad unchanged.
- R4: A move-external access (req_mode = 2) with xram_off = 0 and req_addr below 300h reaches expanded RAM byte req_addr. No external request is raised.
- R5: A move-external access with xram_off = 0 and req_addr at or above 300h asserts ext_req, with ext_addr = req_addr, ext_we = req_wr and ext_wdata = req_wdata.
- R6: A move-external access with xram_off = 1 asserts ext_req for every address and leaves the expanded RAM unchanged.
- R7: A read raises rd_valid in the next cycle. rd_data then carries the byte that was stored, or the sfr_rdata / ext_rdata value present during the request cycle.
- R8: A write to internal RAM takes effect at the end of its strobe cycle, so a read in the following cycle returns the new byte.
- R9: When req_rd and req_wr are both high, the access is a write only, and rd_valid stays low in the next cycle.
- R10: req_mode = 3 is reserved. It raises no request, changes no storage and produces no rd_valid.
- R11: While rst_n is low, rd_valid, sfr_req and ext_req are low and strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_mode | input | 2 | 0 direct, 1 indirect, 2 move-external, 3 reserved |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| xram_off | input | 1 | 1 sends all move-external accesses to the external bus |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| sfr_req | output | 1 | SFR bus request |
| sfr_we | output | 1 | SFR write |
| sfr_addr | output | 8 | SFR address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, sampled in the request cycle |
| ext_req | output | 1 | External bus request |
| ext_we | output | 1 | External write |
| ext_addr | output | 16 | External address |
| ext_wdata | output | 8 | External write data |
| ext_rdata | input | 8 | External read data, sampled in the request cycle |

## Verification
The bench targets the 80h boundary. A direct write there that reached the scratchpad would show up as a corrupted byte on a later indirect read of the same address. It probes 2FFh against 300h and writes with xram_off set, which would expose a wrong limit compare or leaked expanded-RAM writes. It also covers direct accesses with high address bits set, combined read and write strobes, and the reserved mode. A decoder that ignored these cases would raise a stray request, return an extra rd_valid, or alter stored bytes that later reads reveal.

// File: rtl/dmem_route_pkg.sv
package dmem_route_pkg;

   typedef enum logic [1:0] {
      AM_DIRECT   = 2'd0,
      AM_INDIRECT = 2'd1,
      AM_MOVX     = 2'd2,
      AM_RSVD     = 2'd3
   } amode_t;

   typedef enum logic [2:0] {
      TG_NONE    = 3'd0,
      TG_SCRATCH = 3'd1,
      TG_SFR     = 3'd2,
      TG_XRAM    = 3'd3,
      TG_EXT     = 3'd4
   } target_t;

endpackage

// File: rtl/dmem_route_decode.sv
module dmem_route_decode
   import dmem_route_pkg::*;
#(
   parameter int AW         = 16,
   parameter int SCR_BYTES  = 256,
   parameter int XRAM_BYTES = 768
) (
   input  logic          act,
   input  amode_t        mode,
   input  logic [AW-1:0] addr,
   input  logic          xram_off,
   output target_t       tgt
);
   localparam int SA = $clog2(SCR_BYTES);
   localparam logic [AW:0] XLIM = (AW+1)'(XRAM_BYTES);

   target_t movx_tgt;

   generate
      if (XRAM_BYTES > 0) begin : g_with_xram
         logic in_xram;
         assign in_xram  = ({1'b0, addr} < XLIM);
         assign movx_tgt = (xram_off || !in_xram) ? TG_EXT : TG_XRAM;
      end else begin : g_no_xram
         logic unused_off;
         assign unused_off = xram_off;
         assign movx_tgt   = TG_EXT;
      end
   endgenerate

   always_comb begin
      tgt = TG_NONE;
      if (act) begin
         case (mode)
            AM_DIRECT:   tgt = addr[SA-1] ? TG_SFR : TG_SCRATCH;
            AM_INDIRECT: tgt = TG_SCRATCH;
            AM_MOVX:     tgt = movx_tgt;
            default:     tgt = TG_NONE;
         endcase
      end
   end

endmodule

// File: rtl/dmem_route_bank.sv
module dmem_route_bank #(
   parameter int DEPTH = 256,
   parameter int DW    = 8,
   localparam int BAW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic           clk,
   input  logic           we,
   input  logic           re,
   input  logic [BAW-1:0] addr,
   input  logic [DW-1:0]  wdata,
   output logic [DW-1:0]  rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[addr] <= wdata;
      end
      if (re) begin
         rdata <= mem[addr];
      end
   end

endmodule

// File: rtl/dmem_route_rdret.sv
module dmem_route_rdret
   import dmem_route_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  target_t       tgt,
   input  logic [DW-1:0] sfr_rdata,
   input  logic [DW-1:0] ext_rdata,
   input  logic [DW-1:0] scratch_q,
   input  logic [DW-1:0] xram_q,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data
);
   target_t       sel_q;
   logic [DW-1:0] cap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         sel_q    <= TG_NONE;
         cap_q    <= '0;
      end else begin
         rd_valid <= launch;
         if (launch) begin
            sel_q <= tgt;
            cap_q <= (tgt == TG_SFR) ? sfr_rdata : ext_rdata;
         end
      end
   end

   always_comb begin
      case (sel_q)
         TG_SCRATCH:    rd_data = scratch_q;
         TG_XRAM:       rd_data = xram_q;
         TG_SFR, TG_EXT: rd_data = cap_q;
         default:       rd_data = '0;
      endcase
   end

endmodule

// File: rtl/dmem_route_top.sv
module dmem_route_top
   import dmem_route_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 8,
   parameter int SCR_BYTES  = 256,
   parameter int XRAM_BYTES = 768,
   localparam int SA        = $clog2(SCR_BYTES),
   localparam int XA        = (XRAM_BYTES > 1) ? $clog2(XRAM_BYTES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_rd,
   input  logic          req_wr,
   input  logic [1:0]    req_mode,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          xram_off,
   output logic [DW-1:0] rd_data,
   output logic          rd_valid,
   output logic          sfr_req,
   output logic          sfr_we,
   output logic [SA-1:0] sfr_addr,
   output logic [DW-1:0] sfr_wdata,
   input  logic [DW-1:0] sfr_rdata,
   output logic          ext_req,
   output logic          ext_we,
   output logic [AW-1:0] ext_addr,
   output logic [DW-1:0] ext_wdata,
   input  logic [DW-1:0] ext_rdata
);
   generate
      if (SCR_BYTES != (1 << SA)) begin : g_bad_scr
         $error("SCR_BYTES must be a power of two");
      end
      if (SA > AW) begin : g_bad_aw
         $error("address width narrower than scratchpad index");
      end
      if (XRAM_BYTES > (1 << AW)) begin : g_bad_xram
         $error("XRAM_BYTES exceeds the address space");
      end
   endgenerate

   amode_t  mode;
   target_t tgt;
   logic    act, is_rd;
   logic    scr_en, scr_we, scr_re;
   logic    xr_en;
   logic [DW-1:0] scratch_q, xram_q;

   assign mode  = amode_t'(req_mode);
   assign act   = rst_n & (req_rd | req_wr);
   assign is_rd = req_rd & ~req_wr;

   dmem_route_decode #(
      .AW(AW), .SCR_BYTES(SCR_BYTES), .XRAM_BYTES(XRAM_BYTES)
   ) u_decode (
      .act(act), .mode(mode), .addr(req_addr), .xram_off(xram_off), .tgt(tgt)
   );

   assign scr_en = (tgt == TG_SCRATCH);
   assign scr_we = scr_en & req_wr;
   assign scr_re = scr_en & is_rd;

   dmem_route_bank #(.DEPTH(SCR_BYTES), .DW(DW)) u_scratch (
      .clk(clk), .we(scr_we), .re(scr_re), .addr(req_addr[SA-1:0]),
      .wdata(req_wdata), .rdata(scratch_q)
   );

   generate
      if (XRAM_BYTES > 0) begin : g_xram
         logic xr_we, xr_re;
         assign xr_en = (tgt == TG_XRAM);
         assign xr_we = xr_en & req_wr;
         assign xr_re = xr_en & is_rd;
         dmem_route_bank #(.DEPTH(XRAM_BYTES), .DW(DW)) u_xram (
            .clk(clk), .we(xr_we), .re(xr_re), .addr(req_addr[XA-1:0]),
            .wdata(req_wdata), .rdata(xram_q)
         );
      end else begin : g_noxram
         assign xr_en  = 1'b0;
         assign xram_q = '0;
      end
   endgenerate

   assign sfr_req   = (tgt == TG_SFR);
   assign sfr_we    = sfr_req & req_wr;
   assign sfr_addr  = req_addr[SA-1:0];
   assign sfr_wdata = req_wdata;

   assign ext_req   = (tgt == TG_EXT);
   assign ext_we    = ext_req & req_wr;
   assign ext_addr  = req_addr;
   assign ext_wdata = req_wdata;

   dmem_route_rdret #(.DW(DW)) u_rdret (
      .clk(clk), .rst_n(rst_n), .launch(act & is_rd & (tgt != TG_NONE)),
      .tgt(tgt), .sfr_rdata(sfr_rdata), .ext_rdata(ext_rdata),
      .scratch_q(scratch_q), .xram_q(xram_q),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   AST_SFR_DIRECT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      sfr_req |-> (req_mode == 2'd0 && req_addr[SA-1])); // R3
   AST_SCR_NOT_DIRECT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (scr_we && req_mode == 2'd0) |-> !req_addr[SA-1]); // R1
   AST_EXT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_req && !xram_off) |-> ({1'b0, req_addr} >= (AW+1)'(XRAM_BYTES))); // R5
   AST_XOFF_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (xram_off && req_mode == 2'd2 && (req_rd || req_wr)) |-> (ext_req && !xr_en)); // R6
   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sfr_req, ext_req, scr_en, xr_en})); // R4
   AST_RD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_rd && !req_wr && req_mode != 2'd3) |=> rd_valid); // R7
   AST_WR_NO_RET: assert property (@(posedge clk) disable iff (!rst_n)
      req_wr |=> !rd_valid); // R9
   AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_mode == 2'd3) |-> (!sfr_req && !ext_req && !scr_en && !xr_en)); // R10

   always_comb begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!sfr_req && !ext_req); // R11
      end
   end

endmodule

// File: tb/dmem_route_top_test.sv
`timescale 1ns/1ps
module dmem_route_top_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_rd, req_wr, xram_off;
   logic [1:0]  req_mode;
   logic [15:0] req_addr;
   logic [7:0]  req_wdata, sfr_rdata, ext_rdata;
   logic [7:0]  rd_data, sfr_addr, sfr_wdata, ext_wdata;
   logic        rd_valid, sfr_req, sfr_we, ext_req, ext_we;
   logic [15:0] ext_addr;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   byte unsigned m_scr [256];
   byte unsigned m_xr  [768];

   always #4 clk = ~clk;

   dmem_route_top uut (
      .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
      .req_mode(req_mode), .req_addr(req_addr), .req_wdata(req_wdata),
      .xram_off(xram_off), .rd_data(rd_data), .rd_valid(rd_valid),
      .sfr_req(sfr_req), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
      .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ext_req(ext_req),
      .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
      .ext_rdata(ext_rdata)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // target codes: 0 none, 1 scratch, 2 sfr, 3 expanded RAM, 4 external
   task automatic step(input int m, input int a, input bit rd, input bit wr,
                       input int wd, input bit xo);
      int tg;
      string tag;
      logic [63:0] ec, ac;
      bit ev;
      logic [7:0] ed;
      req_mode = 2'(m); req_addr = 16'(a); req_rd = rd; req_wr = wr;
      req_wdata = 8'(wd); xram_off = xo;
      sfr_rdata = 8'($urandom); ext_rdata = 8'($urandom);
      #1;
      tg = 0;
      if (rd || wr) begin
         if (m == 0) tg = (a % 256 >= 128) ? 2 : 1;
         else if (m == 1) tg = 1;
         else if (m == 2) tg = (xo || a >= 768) ? 4 : 3;
      end
      if (rd && wr)       tag = "R9";
      else if (tg == 0)   tag = "R10";
      else if (tg == 1)   tag = (m == 0) ? "R1" : "R2";
      else if (tg == 2)   tag = "R3";
      else if (tg == 3)   tag = "R4";
      else                tag = xo ? "R6" : "R5";
      ec = {28'd0, (tg == 2), (tg == 4), (tg == 2) && wr, (tg == 4) && wr,
            (tg == 2) ? 8'(a) : 8'h00, (tg == 4) ? 16'(a) : 16'h0000,
            ((tg == 2 || tg == 4) && wr) ? 8'(wd) : 8'h00};
      ac = {28'd0, sfr_req, ext_req, sfr_req && sfr_we, ext_req && ext_we,
            sfr_req ? sfr_addr : 8'h00, ext_req ? ext_addr : 16'h0000,
            (sfr_req && sfr_we) ? sfr_wdata : ((ext_req && ext_we) ? ext_wdata : 8'h00)};
      check(tag, ac, ec);
      ev = rd && !wr && tg != 0;
      ed = 8'h00;
      if (ev) begin
         case (tg)
            1: ed = m_scr[a % 256];
            2: ed = sfr_rdata;
            3: ed = m_xr[a];
            default: ed = ext_rdata;
         endcase
      end
      if (wr && tg == 1) m_scr[a % 256] = 8'(wd);
      if (wr && tg == 3) m_xr[a] = 8'(wd);
      @(posedge clk);
      @(negedge clk);
      check(ev ? "R7" : tag, {55'd0, rd_valid, ev ? rd_data : 8'h00}, {55'd0, ev, ed});
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req_rd = 1'b0; req_wr = 1'b0; req_mode = 2'd0;
      req_addr = 16'h0; req_wdata = 8'h0; xram_off = 1'b0;
      sfr_rdata = 8'h0; ext_rdata = 8'h0;
      @(negedge clk);
      // R11: strobes during reset are quiet
      req_rd = 1'b1; req_addr = 16'h0090; #1;
      check("R11", {62'd0, sfr_req, ext_req}, 64'd0);
      req_mode = 2'd2; req_addr = 16'h1234; #1;
      check("R11", {62'd0, sfr_req, ext_req}, 64'd0);
      @(posedge clk); @(negedge clk);
      check("R11", {63'd0, rd_valid}, 64'd0);
      req_rd = 1'b0; rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 256; i++) step(1, i, 0, 1, (i * 7 + 3) & 255, 0);
      for (int i = 0; i < 768; i++) step(2, i, 0, 1, (i * 13 + 5) & 255, 0);
      // directed corners
      step(0, 16'hAB12, 1, 0, 0, 0);          // R1 high bits ignored
      step(1, 16'h0090, 1, 0, 0, 0);          // R2 upper scratch
      step(0, 16'h0090, 0, 1, 8'hEE, 0);      // R3 SFR write
      step(1, 16'h0090, 1, 0, 0, 0);          // R3 scratch untouched
      step(0, 16'h00FF, 1, 0, 0, 0);          // R3 SFR read
      step(2, 16'h02FF, 1, 0, 0, 0);          // R4 last byte
      step(2, 16'h0300, 1, 0, 0, 0);          // R5 first external
      step(2, 16'h0300, 0, 1, 8'h44, 0);      // R5 external write
      step(2, 16'h0005, 0, 1, 8'h99, 1);      // R6 goes out
      step(2, 16'h0005, 1, 0, 0, 0);          // R6 xram untouched
      step(0, 16'h0021, 0, 1, 8'h5C, 0);      // R8 write
      step(0, 16'h0021, 1, 0, 0, 0);          // R8 read back next cycle
      step(1, 16'h0042, 1, 1, 8'h77, 0);      // R9 both strobes
      step(1, 16'h0042, 1, 0, 0, 0);          // R9 write happened
      step(3, 16'h0042, 0, 1, 8'h11, 0);      // R10 reserved write
      step(3, 16'h0042, 1, 0, 0, 0);          // R10 no read
      step(1, 16'h0042, 1, 0, 0, 0);          // R10 storage unchanged
      for (int i = 0; i < 3000; i++) begin
         int m, a, r;
         m = $urandom_range(0, 3);
         r = $urandom_range(0, 9);
         if (m == 2) a = (r < 3) ? $urandom_range(760, 775) : $urandom_range(0, 65535);
         else a = $urandom_range(0, 65535);
         if (m != 2 && r < 4) a = $urandom_range(120, 135);
         step(m, a, $urandom_range(0, 1), ($urandom_range(0, 2) == 0),
              $urandom_range(0, 255), ($urandom_range(0, 3) == 0));
      end
      req_rd = 1'b0; req_wr = 1'b0;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule